// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the register set that software uses to steer one channel of a bus-master disk DMA engine. It has a command byte with a start bit and a transfer direction bit, and a status byte that reports an active flag, sticky error and interrupt flags, and two general bits that software may use freely. It also keeps a 32-bit base address for the descriptor table and a current table pointer that the descriptor walker uses. Software reaches all of this over a simple 32-bit register bus with byte enables. There are two word slots. Word 0 carries the command byte in lane 0 and the status byte in lane 2. Word 1 carries the base address.

A transfer begins only when a write changes the start bit from 0 to 1, and ends when a write changes it from 1 to 0. A write that leaves the start bit at its current value does nothing to the transfer. The walker receives one-cycle start and cancel pulses, a level that tells it a transfer is active, and the direction. It reports back with a step pulse, a done pulse and an error pulse. The drive interrupt line reaches the host directly. Each rising edge on it also sets the interrupt flag in the status byte.

All ports are plain control and status pins. There is no valid/ready stream at this edge and no back-pressure: a write takes effect on the clock edge where `bus_wr` is high, and `bus_rdata` shows the word selected by `bus_addr` at all times, because reads have no side effects.

Top module: `bm_chan_regs`

## Requirements
- R1: The command byte (word 0, lane 0) keeps only bit 0 (start) and bit 3 (direction). All other bits read as zero, and `xfer_dir` equals the stored bit 3.
- R2: A command write whose bit 0 equals the stored start bit causes no start pulse and no cancel pulse. It does not reload the table pointer and does not change the active flag.
- R3: When a command write changes start from 0 to 1, the table pointer is loaded from the base address and the active flag (status bit 0) is set. `xfer_start` pulses for one cycle if the active flag was clear. When a write changes start from 1 to 0, `xfer_cancel` pulses for one cycle and the active flag clears.
- R4: A status write (word 0, lane 2) stores bits 5 and 6 as written and leaves bit 0 unchanged. Bits 3, 4 and 7 always read as zero.
- R5: The error flag (status bit 1) is set by an `eng_err` pulse and clears only when a status write has bit 1 at 1. The interrupt flag (status bit 2) clears only when a status write has bit 2 at 1. Writing 0 leaves either flag unchanged.
- R6: `host_irq` follows `drv_irq` in the same cycle. A rising edge on `drv_irq` sets status bit 2 at the next clock edge. A falling edge does not touch bit 2.
- R7: Word 1 holds the base address. A write updates only the byte lanes whose enable is set, and bits 1:0 always read as zero.
- R8: While reset is asserted, command, status, base address and table pointer are all zero, and `xfer_start`, `xfer_cancel` and `xfer_active` are low.
- R9: An `eng_done` pulse clears the active flag and leaves the stored start bit unchanged.
- R10: Each `eng_next` pulse advances the table pointer by one descriptor (8 bytes). A start load in the same cycle takes precedence over the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 command/status, 1 base address |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| drv_irq | input | 1 | Interrupt level from the drive |
| eng_next | input | 1 | Walker finished one descriptor |
| eng_done | input | 1 | Walker finished the transfer (engine idle) |
| eng_err | input | 1 | Walker detected an error |
| xfer_start | output | 1 | One-cycle pulse to begin a transfer |
| xfer_cancel | output | 1 | One-cycle pulse to abandon a transfer |
| xfer_active | output | 1 | Active flag (status bit 0) |
| xfer_dir | output | 1 | Direction bit from the command byte |
| tbl_ptr | output | 32 | Current descriptor table pointer |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The command byte is driven through rising, falling and repeated start values, and the same-value cases are placed directly after real edges. This separates an edge-sensitive start bit from a level-sensitive one by looking at the pulses and at a table pointer that the walker has already stepped. The status byte gets writes of 0, a single 1 in each flag position, and all ones, while error, interrupt and active are set. These writes separate write-one-to-clear bits, plain read/write bits, read-only bits and reserved bits. The base register is written with full and partial byte enables using values whose low bits are ones, which exposes lane leakage and any missing alignment mask.

// File: rtl/bm_pkg.sv
package bm_pkg;
  // command byte fields
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_DIR_BIT = 3;
  localparam logic [7:0] CMD_KEEP = 8'h09;
  // status byte fields
  localparam int ST_ACT_BIT = 0;
  localparam int ST_ERR_BIT = 1;
  localparam int ST_INT_BIT = 2;
  localparam logic [7:0] ST_RW_KEEP = 8'h60;
  // byte lanes of word 0
  localparam int LANE_CMD = 0;
  localparam int LANE_ST  = 2;
  // word selects
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_BASE = 1'b1;

  typedef struct packed {
    logic rise;   // start 0 -> 1 seen in this write
    logic fall;   // start 1 -> 0 seen in this write
  } go_edge_t;
endpackage

// File: rtl/bm_cmd_reg.sv
module bm_cmd_reg
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic       act_now,
  output go_edge_t   edge_o,
  output logic [7:0] cmd_o,
  output logic       kick_q,
  output logic       cancel_q
);
  logic [7:0] cmd_q;
  logic       go_q;

  assign go_q = cmd_q[CMD_GO_BIT];
  assign edge_o.rise = wr &&  wbyte[CMD_GO_BIT] && !go_q;
  assign edge_o.fall = wr && !wbyte[CMD_GO_BIT] &&  go_q;
  assign cmd_o = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      kick_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (wr) cmd_q <= wbyte & CMD_KEEP;
      kick_q   <= edge_o.rise && !act_now;
      cancel_q <= edge_o.fall;
    end
  end

  AST_NO_EDGE_ON_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wbyte[CMD_GO_BIT] == go_q)) |=> (!kick_q && !cancel_q)); // R2
endmodule

// File: rtl/bm_status_reg.sv
module bm_status_reg
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  go_edge_t   go_edge,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       drv_irq,
  output logic [7:0] st_o
);
  logic       act_q, err_q, int_q, irq_prev_q;
  logic [7:0] rw_q;
  logic       irq_rise;

  assign irq_rise = drv_irq && !irq_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      err_q      <= 1'b0;
      int_q      <= 1'b0;
      rw_q       <= '0;
      irq_prev_q <= 1'b0;
    end else begin
      irq_prev_q <= drv_irq;
      // active flag: register writes win over the walker's done pulse
      if (go_edge.rise)      act_q <= 1'b1;
      else if (go_edge.fall) act_q <= 1'b0;
      else if (eng_done)     act_q <= 1'b0;
      // sticky flags: a new event wins over a clear in the same cycle
      if (eng_err)                      err_q <= 1'b1;
      else if (wr && wbyte[ST_ERR_BIT]) err_q <= 1'b0;
      if (irq_rise)                     int_q <= 1'b1;
      else if (wr && wbyte[ST_INT_BIT]) int_q <= 1'b0;
      if (wr) rw_q <= wbyte & ST_RW_KEEP;
    end
  end

  always_comb begin
    st_o = rw_q;
    st_o[ST_ACT_BIT] = act_q;
    st_o[ST_ERR_BIT] = err_q;
    st_o[ST_INT_BIT] = int_q;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr && wbyte[ST_ERR_BIT])) |=> err_q); // R5
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !(wr && wbyte[ST_INT_BIT])) |=> int_q); // R5
  AST_INT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> int_q); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !go_edge.rise) |=> !act_q); // R9
endmodule

// File: rtl/bm_addr_reg.sv
module bm_addr_reg #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W/8-1:0] be,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              load,
  input  logic              step,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int LANES = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] KEEP_MASK = {ADDR_W{1'b1}} << ALIGN_BITS;
  localparam logic [ADDR_W-1:0] STEP_AMT  = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] base_q, ptr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q[8*l +: 8] <= '0;
      else if (wr && be[l]) base_q[8*l +: 8] <= wdata[8*l +: 8] & KEEP_MASK[8*l +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= base_q;
    else if (step) ptr_q <= ptr_q + STEP_AMT;
  end

  assign base_o = base_q;
  assign ptr_o  = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr_q == $past(ptr_q) + STEP_AMT)); // R10
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr) |=> (ptr_q == base_q)); // R3
endmodule

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
  import bm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [ADDR_W/8-1:0] bus_be,
  input  logic [ADDR_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] bus_rdata,
  input  logic              drv_irq,
  input  logic              eng_next,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              xfer_start,
  output logic              xfer_cancel,
  output logic              xfer_active,
  output logic              xfer_dir,
  output logic [ADDR_W-1:0] tbl_ptr,
  output logic              host_irq
);
  logic       cmd_wr, st_wr, base_wr;
  logic [7:0] cmd_byte, st_byte;
  go_edge_t   go_edge;
  logic [ADDR_W-1:0] base_val;

  assign cmd_wr  = bus_wr && (bus_addr == SEL_CTRL) && bus_be[LANE_CMD];
  assign st_wr   = bus_wr && (bus_addr == SEL_CTRL) && bus_be[LANE_ST];
  assign base_wr = bus_wr && (bus_addr == SEL_BASE);

  bm_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr),
    .wbyte(bus_wdata[8*LANE_CMD +: 8]), .act_now(st_byte[ST_ACT_BIT]),
    .edge_o(go_edge), .cmd_o(cmd_byte), .kick_q(xfer_start), .cancel_q(xfer_cancel)
  );

  bm_status_reg u_st (
    .clk(clk), .rst_n(rst_n), .wr(st_wr), .wbyte(bus_wdata[8*LANE_ST +: 8]),
    .go_edge(go_edge), .eng_done(eng_done), .eng_err(eng_err),
    .drv_irq(drv_irq), .st_o(st_byte)
  );

  bm_addr_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .DESC_BYTES(DESC_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr(base_wr), .be(bus_be), .wdata(bus_wdata),
    .load(go_edge.rise), .step(eng_next), .base_o(base_val), .ptr_o(tbl_ptr)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == SEL_BASE) begin
      bus_rdata = base_val;
    end else begin
      bus_rdata[8*LANE_CMD +: 8] = cmd_byte;
      bus_rdata[8*LANE_ST  +: 8] = st_byte;
    end
  end

  assign xfer_active = st_byte[ST_ACT_BIT];
  assign xfer_dir    = cmd_byte[CMD_DIR_BIT];
  assign host_irq    = drv_irq;

  AST_KICK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (xfer_active && cmd_byte[CMD_GO_BIT])); // R3
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cancel |-> (!xfer_active && !cmd_byte[CMD_GO_BIT])); // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_start, xfer_cancel})); // R3
endmodule

// File: tb/test_bm_chan_regs.sv
module test_bm_chan_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 0 read data, 1 control vector, 2 table pointer
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_addr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tbl_ptr;
  logic        drv_irq = 1'b0, eng_next = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic        xfer_start, xfer_cancel, xfer_active, xfer_dir, host_irq;

  int    n_chk = 0, n_err = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  bm_chan_regs i_bm_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_irq(drv_irq),
    .eng_next(eng_next), .eng_done(eng_done), .eng_err(eng_err),
    .xfer_start(xfer_start), .xfer_cancel(xfer_cancel), .xfer_active(xfer_active),
    .xfer_dir(xfer_dir), .tbl_ptr(tbl_ptr), .host_irq(host_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      wait (sb.size() != 0);
      begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {27'd0, host_irq, xfer_start, xfer_cancel, xfer_active, xfer_dir};
          default: act = tbl_ptr;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic chk_rd(logic a, logic [31:0] exp, string req);
    bus_addr = a;
    #1;
    push(0, exp, req);
  endtask

  // control vector order: {host_irq, xfer_start, xfer_cancel, xfer_active, xfer_dir}
  task automatic chk_ctl(logic [4:0] exp, string req);
    push(1, {27'd0, exp}, req);
  endtask

  task automatic chk_ptr(logic [31:0] exp, string req);
    push(2, exp, req);
  endtask

  task automatic wr(logic a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk_rd(0, 32'h0, "R8"); chk_rd(1, 32'h0, "R8");
    chk_ctl(5'b00000, "R8"); chk_ptr(32'h0, "R8");
    rst_n = 1'b1;

    // R7 base address lanes and alignment
    wr(1, 4'b1111, 32'hFFFF_FFFF); chk_rd(1, 32'hFFFF_FFFC, "R7");
    wr(1, 4'b0010, 32'h1234_5678); chk_rd(1, 32'hFFFF_56FC, "R7");
    wr(1, 4'b0001, 32'h0000_007B); chk_rd(1, 32'hFFFF_5678, "R7");

    // R3 start rising edge, R1 command storage
    wr(0, 4'b0001, 32'h0000_00FF);
    chk_ctl(5'b01011, "R3"); chk_ptr(32'hFFFF_5678, "R3");
    chk_rd(0, 32'h0001_0009, "R1");

    // R10 walker step
    @(negedge clk); eng_next = 1'b1; @(negedge clk); eng_next = 1'b0;
    chk_ptr(32'hFFFF_5680, "R10");

    // R2 rewrite of start=1: no pulse, no reload, direction now 0 (R1)
    wr(0, 4'b0001, 32'h0000_0001);
    chk_ctl(5'b00010, "R2"); chk_ptr(32'hFFFF_5680, "R2");
    chk_rd(0, 32'h0001_0001, "R1");

    // R3 falling edge cancels
    wr(0, 4'b0001, 32'h0);
    chk_ctl(5'b00100, "R3"); chk_rd(0, 32'h0, "R3");
    // R2 rewrite of start=0
    wr(0, 4'b0001, 32'h0);
    chk_ctl(5'b00000, "R2");

    // R3 restart reloads pointer
    wr(0, 4'b0001, 32'h0000_0001);
    chk_ctl(5'b01010, "R3"); chk_ptr(32'hFFFF_5678, "R3");

    // R9 done clears active, start bit kept
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    chk_ctl(5'b00000, "R9"); chk_rd(0, 32'h0000_0001, "R9");

    // R5 error set
    @(negedge clk); eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
    chk_rd(0, 32'h0002_0001, "R5");

    // R6 interrupt
    @(negedge clk); drv_irq = 1'b1; #1;
    chk_ctl(5'b10000, "R6");
    @(negedge clk); chk_rd(0, 32'h0006_0001, "R6");
    drv_irq = 1'b0; #1;
    chk_ctl(5'b00000, "R6");
    @(negedge clk); chk_rd(0, 32'h0006_0001, "R6");

    // R5 write-one-to-clear
    wr(0, 4'b0100, 32'h0000_0000); chk_rd(0, 32'h0006_0001, "R5");
    wr(0, 4'b0100, 32'h0002_0000); chk_rd(0, 32'h0004_0001, "R5");
    // R4 plain bits, reserved bits read zero, interrupt cleared
    wr(0, 4'b0100, 32'h00FF_0000); chk_rd(0, 32'h0060_0001, "R4");

    // R4 active bit unaffected by status writes
    wr(0, 4'b0001, 32'h0); wr(0, 4'b0001, 32'h0000_0001);
    chk_rd(0, 32'h0061_0001, "R4");
    wr(0, 4'b0100, 32'h0000_0000); chk_rd(0, 32'h0001_0001, "R4");
    chk_ctl(5'b00010, "R4");

    // R8 reset while active
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_rd(0, 32'h0, "R8"); chk_rd(1, 32'h0, "R8");
    chk_ctl(5'b00000, "R8"); chk_ptr(32'h0, "R8");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule